// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the control unit and register datapath of a small accumulator machine. It walks every instruction through the fetch, indirect, execute and interrupt subcycles. It moves words between a program counter, an instruction register, a memory address register (MAR), a memory buffer register (MBR) and an accumulator. Only the MAR drives the memory address, and only the MBR sends or receives memory data. The memory is a single-port synchronous RAM outside the block. It gets a one-cycle read strobe and a one-cycle write strobe, and it returns read data on the clock edge after the read strobe.

The instruction word is 16 bits wide: bit 15 asks for an indirect operand, bits 14..12 select the operation and bits 11..0 carry the address. After each execute subcycle the sequencer checks an interrupt-enable flag and an interrupt request. When both are set, it stores the program counter at a fixed save location, jumps to a fixed handler address and clears the enable flag.

Top module: `ics_top`

## Requirements
- R1: A synchronous active-high reset clears the program counter, instruction register, MAR, MBR, accumulator and interrupt-enable flag. It deasserts both strobes, clears the halted flag and leaves the sequencer at the start of fetch.
- R2: In the first cycle after reset, the read strobe is high with the memory address equal to the program counter (0). The program counter becomes 1 one cycle later, while the memory access is still in progress.
- R3: Bit 15 of the instruction is the indirect flag, bits 11..0 are the address, and bits 14..12 give the operation: 0 load, 1 store, 2 add, 3 jump, 4 enable interrupts, 7 halt. Codes 5 and 6 change no register except the program counter advance from fetch.
- R4: Load sets the accumulator to the memory word at the operand address. Add sets it to the old accumulator plus that word, modulo 2^16.
- R5: Store writes the accumulator to the operand address through the MBR.
- R6: When bit 15 is set, an indirect subcycle reads the word at the address field and uses its low 12 bits as the operand address. The phase output shows 1 during this subcycle, and the subcycle never runs for instructions with bit 15 clear.
- R7: Jump loads the program counter with the operand address.
- R8: Each strobe is high for a single cycle at a time, and the read and write strobes are never high together.
- R9: An interrupt is taken after an execute subcycle only when the enable flag and the request are both high. Taking it writes the program counter to SAVE_ADDR, loads VEC_ADDR into the program counter and clears the enable flag. A request with the flag clear has no effect.
- R10: The enable-interrupts operation sets the enable flag.
- R11: Halt raises the halted output and holds the sequencer until reset, with no strobes and a stable program counter.
- R12: The phase output reads 0 during fetch and decode, 1 during indirect, 2 during execute (including halted) and 3 during interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Interrupt request level |
| mem_rdata | input | DW | Read data, valid the cycle after a read strobe |
| mem_addr | output | AW | Memory address, driven by the MAR |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DW | Write data, driven by the MBR |
| acc | output | DW | Accumulator |
| pc | output | AW | Program counter |
| int_en | output | 1 | Interrupt-enable flag |
| halted | output | 1 | High while parked by halt |
| phase | output | 2 | Current subcycle code |

## Verification
The bench keeps the default 16-bit word and 12-bit address. It moves the save location to 0x0F0 and the handler vector to 0x080, so both sit in a small memory image next to the test programs and data. With these values the test can read back the stored return address directly. It can also place a handler that itself loads from memory, which shows that a request still held high after the enable flag clears does not trigger a second interrupt.

// File: rtl/ics_pkg.sv
package ics_pkg;

  typedef enum logic [4:0] {
    S_F0, S_F1, S_F2, S_F3, S_DEC,
    S_I0, S_I1, S_I2, S_I3,
    S_E0, S_E1, S_E2, S_E3, S_ES,
    S_CHK, S_INT0, S_INT1, S_HALT
  } state_t;

  localparam logic [2:0] OP_LOAD  = 3'd0;
  localparam logic [2:0] OP_STORE = 3'd1;
  localparam logic [2:0] OP_ADD   = 3'd2;
  localparam logic [2:0] OP_JUMP  = 3'd3;
  localparam logic [2:0] OP_EI    = 3'd4;
  localparam logic [2:0] OP_HALT  = 3'd7;

  localparam logic [1:0] PH_FETCH = 2'd0;
  localparam logic [1:0] PH_IND   = 2'd1;
  localparam logic [1:0] PH_EXEC  = 2'd2;
  localparam logic [1:0] PH_INT   = 2'd3;

  function automatic logic [1:0] phase_of(state_t s);
    case (s)
      S_F0, S_F1, S_F2, S_F3, S_DEC: phase_of = PH_FETCH;
      S_I0, S_I1, S_I2, S_I3:        phase_of = PH_IND;
      S_INT0, S_INT1:                phase_of = PH_INT;
      default:                       phase_of = PH_EXEC;
    endcase
  endfunction

endpackage

// File: rtl/ics_ctrl.sv
module ics_ctrl
  import ics_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ind_bit,
  input  logic [2:0] opcode,
  input  logic       int_en,
  input  logic       irq,
  output state_t     state
);

  state_t nxt;

  always_comb begin
    nxt = state;
    case (state)
      S_F0:  nxt = S_F1;
      S_F1:  nxt = S_F2;
      S_F2:  nxt = S_F3;
      S_F3:  nxt = S_DEC;
      S_DEC: nxt = ind_bit ? S_I0 : S_E0;
      S_I0:  nxt = S_I1;
      S_I1:  nxt = S_I2;
      S_I2:  nxt = S_I3;
      S_I3:  nxt = S_E0;
      S_E0: begin
        case (opcode)
          OP_LOAD, OP_ADD: nxt = S_E1;
          OP_STORE:        nxt = S_ES;
          OP_HALT:         nxt = S_HALT;
          default:         nxt = S_CHK;
        endcase
      end
      S_E1:   nxt = S_E2;
      S_E2:   nxt = S_E3;
      S_E3:   nxt = S_CHK;
      S_ES:   nxt = S_CHK;
      S_CHK:  nxt = (int_en && irq) ? S_INT0 : S_F0;
      S_INT0: nxt = S_INT1;
      S_INT1: nxt = S_F0;
      S_HALT: nxt = S_HALT;
      default: nxt = S_F0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_F0;
    else     state <= nxt;
  end

endmodule

// File: rtl/ics_alu.sv
module ics_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] operand,
  input  logic          do_add,
  output logic [DW-1:0] result
);

  always_comb begin
    if (do_add) result = acc_in + operand;
    else        result = operand;
  end

endmodule

// File: rtl/ics_top.sv
module ics_top
  import ics_pkg::*;
#(
  parameter int              DW        = 16,
  parameter int              AW        = 12,
  parameter logic [AW-1:0]   SAVE_ADDR = 12'hFF0,
  parameter logic [AW-1:0]   VEC_ADDR  = 12'h040
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] acc,
  output logic [AW-1:0] pc,
  output logic          int_en,
  output logic          halted,
  output logic [1:0]    phase
);

  localparam int IND_BIT = DW - 1;
  localparam int OP_LSB  = AW;

  state_t        state;
  logic [DW-1:0] ir_q;
  logic [DW-1:0] mbr_q;
  logic [AW-1:0] mar_q;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] acc_q;
  logic          ie_q;
  logic          rd_q;
  logic          wr_q;
  logic [DW-1:0] alu_res;
  logic [2:0]    op;
  logic [AW-1:0] opnd_addr;

  assign op        = ir_q[OP_LSB+2:OP_LSB];
  assign opnd_addr = ir_q[AW-1:0];

  ics_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ind_bit (ir_q[IND_BIT]),
    .opcode  (op),
    .int_en  (ie_q),
    .irq     (irq),
    .state   (state)
  );

  ics_alu #(.DW(DW)) u_alu (
    .acc_in  (acc_q),
    .operand (mbr_q),
    .do_add  (op == OP_ADD),
    .result  (alu_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q  <= '0;
      mbr_q <= '0;
      mar_q <= '0;
      pc_q  <= '0;
      acc_q <= '0;
      ie_q  <= 1'b0;
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
      case (state)
        S_F0: begin
          mar_q <= pc_q;
          rd_q  <= 1'b1;
        end
        S_F1: pc_q <= pc_q + 1'b1;
        S_F2, S_I2, S_E2: mbr_q <= mem_rdata;
        S_F3: ir_q <= mbr_q;
        S_I0: begin
          mar_q <= opnd_addr;
          rd_q  <= 1'b1;
        end
        S_I3: ir_q[AW-1:0] <= mbr_q[AW-1:0];
        S_E0: begin
          case (op)
            OP_LOAD, OP_ADD: begin
              mar_q <= opnd_addr;
              rd_q  <= 1'b1;
            end
            OP_STORE: begin
              mar_q <= opnd_addr;
              mbr_q <= acc_q;
              wr_q  <= 1'b1;
            end
            OP_JUMP: pc_q <= opnd_addr;
            OP_EI:   ie_q <= 1'b1;
            default: ;
          endcase
        end
        S_E3: acc_q <= alu_res;
        S_INT0: begin
          mar_q <= SAVE_ADDR;
          mbr_q <= DW'(pc_q);
          wr_q  <= 1'b1;
          ie_q  <= 1'b0;
        end
        S_INT1: pc_q <= VEC_ADDR;
        default: ;
      endcase
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;
  assign mem_rd    = rd_q;
  assign mem_wr    = wr_q;
  assign acc       = acc_q;
  assign pc        = pc_q;
  assign int_en    = ie_q;
  assign halted    = (state == S_HALT);
  assign phase     = phase_of(state);

endmodule

// File: rtl/ics_checker.sv
module ics_checker #(
  parameter int            DW        = 16,
  parameter int            AW        = 12,
  parameter logic [AW-1:0] SAVE_ADDR = 12'hFF0
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [DW-1:0] mem_wdata,
  input logic [AW-1:0] pc,
  input logic          int_en,
  input logic          halted,
  input logic [1:0]    phase
);

  logic [DW-1:0] wdata_seen;
  assign wdata_seen = mem_wdata;

  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R8
  AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd); // R8
  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> !mem_wr); // R8
  AST_FETCH_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd0 && mem_rd) |=> pc == AW'($past(mem_addr) + 1'b1)); // R2
  AST_HALT_PARKED: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc) && !mem_rd && !mem_wr)); // R11
  AST_INT_SAVE_MASKS: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd3 && mem_wr) |-> (!int_en && mem_addr == SAVE_ADDR
                                   && wdata_seen[AW-1:0] == pc)); // R9
  AST_HALT_PHASE: assert property (@(posedge clk) disable iff (rst)
    halted |-> phase == 2'd2); // R12

endmodule

bind ics_top ics_checker #(.DW(DW), .AW(AW), .SAVE_ADDR(SAVE_ADDR)) u_ics_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_addr  (mem_addr),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_wdata (mem_wdata),
  .pc        (pc),
  .int_en    (int_en),
  .halted    (halted),
  .phase     (phase)
);

// File: tb/ics_top_test.sv
module ics_top_test;

  localparam int            DW   = 16;
  localparam int            AW   = 12;
  localparam logic [AW-1:0] SAVE = 12'h0F0;
  localparam logic [AW-1:0] VEC  = 12'h080;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          irq = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] acc;
  logic [AW-1:0] pc;
  logic          int_en, halted;
  logic [1:0]    phase;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic          tb_we = 1'b0;
  logic [AW-1:0] tb_addr = '0;
  logic [DW-1:0] tb_data = '0;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  int strobes = 0;
  logic saw_ind = 1'b0;

  always #4 clk = ~clk;

  ics_top #(.DW(DW), .AW(AW), .SAVE_ADDR(SAVE), .VEC_ADDR(VEC)) uut (
    .clk(clk), .rst(rst), .irq(irq), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .acc(acc), .pc(pc), .int_en(int_en),
    .halted(halted), .phase(phase)
  );

  always @(posedge clk) begin
    if (tb_we) mem[tb_addr] <= tb_data;
    else if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst && phase == 2'd1) saw_ind = 1'b1;
    if (!rst && (mem_rd || mem_wr)) strobes++;
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp, string what);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic poke(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = a; tb_data = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic release_reset();
    @(negedge clk);
    saw_ind = 1'b0;
    rst = 1'b0;
  endtask

  task automatic run_to_halt(string req);
    int n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(req, {31'd0, halted}, 32'd1, "halt reached");
  endtask

  task automatic t_reset();
    hold_reset();
    check("R1", {20'd0, pc}, 32'd0, "pc after reset");
    check("R1", {16'd0, acc}, 32'd0, "acc after reset");
    check("R1", {31'd0, int_en}, 32'd0, "int_en after reset");
    check("R1", {30'd0, mem_rd, mem_wr}, 32'd0, "strobes after reset");
    check("R1", {31'd0, halted}, 32'd0, "halted after reset");
    check("R1", {30'd0, phase}, 32'd0, "phase after reset");
  endtask

  task automatic t_fetch();
    hold_reset();
    poke(12'h000, 16'h7000);
    release_reset();
    @(posedge clk); #1;
    check("R2", {30'd0, mem_rd, mem_wr}, 32'd2, "read strobe first cycle");
    check("R2", {20'd0, mem_addr}, 32'd0, "fetch address");
    check("R2", {20'd0, pc}, 32'd0, "pc not yet advanced");
    @(posedge clk); #1;
    check("R2", {31'd0, mem_rd}, 32'd0, "read strobe dropped");
    check("R2", {20'd0, pc}, 32'd1, "pc advanced during access");
    run_to_halt("R11");
  endtask

  task automatic t_direct();
    logic [AW-1:0] pc_hold;
    hold_reset();
    poke(12'h000, 16'h0100);
    poke(12'h001, 16'h2101);
    poke(12'h002, 16'h5000);
    poke(12'h003, 16'h1102);
    poke(12'h004, 16'h7000);
    poke(12'h100, 16'd5);
    poke(12'h101, 16'd7);
    poke(12'h102, 16'h0000);
    release_reset();
    run_to_halt("R11");
    check("R4", {16'd0, acc}, 32'd12, "load then add");
    check("R3", {20'd0, pc}, 32'd5, "no-op code only advances pc");
    check("R5", {16'd0, mem[12'h102]}, 32'd12, "store result");
    check("R6", {31'd0, saw_ind}, 32'd0, "no indirect phase for direct");
    pc_hold = pc;
    strobes = 0;
    repeat (20) @(negedge clk);
    check("R11", {31'd0, halted}, 32'd1, "still halted");
    check("R11", {20'd0, pc}, {20'd0, pc_hold}, "pc parked");
    check("R11", strobes, 32'd0, "no strobes while halted");
    check("R12", {30'd0, phase}, 32'd2, "phase while halted");
  endtask

  task automatic t_wrap();
    hold_reset();
    poke(12'h000, 16'h0100);
    poke(12'h001, 16'h2101);
    poke(12'h002, 16'h7000);
    poke(12'h100, 16'hFFFF);
    poke(12'h101, 16'h0002);
    release_reset();
    run_to_halt("R11");
    check("R4", {16'd0, acc}, 32'd1, "add wraps modulo 2^16");
  endtask

  task automatic t_indirect();
    hold_reset();
    poke(12'h000, 16'h8110);
    poke(12'h001, 16'h9111);
    poke(12'h002, 16'h7000);
    poke(12'h110, 16'h0120);
    poke(12'h120, 16'h0033);
    poke(12'h111, 16'h0130);
    poke(12'h130, 16'h0000);
    release_reset();
    run_to_halt("R11");
    check("R6", {16'd0, acc}, 32'h33, "indirect load");
    check("R6", {16'd0, mem[12'h130]}, 32'h33, "indirect store");
    check("R6", {16'd0, mem[12'h111]}, 32'h130, "pointer untouched");
    check("R12", {31'd0, saw_ind}, 32'd1, "indirect phase seen");
  endtask

  task automatic t_jump();
    hold_reset();
    poke(12'h000, 16'h3005);
    for (int i = 1; i < 5; i++) poke(AW'(i), 16'h7000);
    poke(12'h005, 16'h0100);
    poke(12'h006, 16'h7000);
    poke(12'h100, 16'd9);
    release_reset();
    run_to_halt("R11");
    check("R7", {20'd0, pc}, 32'd7, "pc after jump path");
    check("R7", {16'd0, acc}, 32'd9, "load at jump target");
  endtask

  task automatic t_ei();
    hold_reset();
    irq = 1'b0;
    poke(12'h000, 16'h4000);
    poke(12'h001, 16'h7000);
    release_reset();
    run_to_halt("R11");
    check("R10", {31'd0, int_en}, 32'd1, "enable flag set");
    check("R10", {20'd0, pc}, 32'd2, "no interrupt without request");
  endtask

  task automatic t_irq_masked();
    hold_reset();
    irq = 1'b1;
    poke(12'h000, 16'h0100);
    poke(12'h001, 16'h7000);
    poke(12'h100, 16'd4);
    poke(SAVE, 16'hDEAD);
    release_reset();
    run_to_halt("R11");
    check("R9", {16'd0, mem[SAVE]}, 32'hDEAD, "masked request leaves save slot");
    check("R9", {20'd0, pc}, 32'd2, "masked request keeps flow");
    check("R9", {16'd0, acc}, 32'd4, "masked request acc");
    irq = 1'b0;
  endtask

  task automatic t_irq_taken();
    hold_reset();
    irq = 1'b1;
    poke(12'h000, 16'h4000);
    poke(12'h001, 16'h0101);
    poke(12'h002, 16'h7000);
    poke(VEC, 16'h0100);
    poke(VEC + 12'd1, 16'h7000);
    poke(12'h100, 16'd3);
    poke(12'h101, 16'd8);
    poke(SAVE, 16'hDEAD);
    release_reset();
    run_to_halt("R11");
    check("R9", {16'd0, mem[SAVE]}, 32'd1, "saved return address");
    check("R9", {20'd0, pc}, {20'd0, VEC} + 32'd2, "handler ran to halt");
    check("R9", {16'd0, acc}, 32'd3, "handler load, no retrigger");
    check("R9", {31'd0, int_en}, 32'd0, "enable flag cleared");
    irq = 1'b0;
  endtask

  initial begin
    while (cycles < 150000) @(negedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_fetch();
    t_direct();
    t_wrap();
    t_indirect();
    t_jump();
    t_ei();
    t_irq_masked();
    t_irq_taken();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule